// File: doc/BRIEF.md
# Serial Master with Graceful Run/Stop Control

This block is a serial peripheral interface master. It takes words from a small transmit queue and shifts each one out as a frame whose length is set between 4 and 16 bits. It samples the return line during the same frame and pushes each received word into a receive queue. A run/stop state machine decides whether new frames may start. Three inhibit sources can stop it: a halt control, a sticky end-of-queue flag, and a freeze control that only counts while debug mode is on.

Stopping never cuts a frame short. A frame already on the wire finishes, and the machine then leaves the running state. When the link is idle, the machine leaves the running state on the next clock. The host can fill and drain both queues at any time, including while the machine is stopped. A transmit word can carry an end-of-queue marker. When the frame for that word ends, the end-of-queue flag is raised and the machine stops until the host clears the flag by writing one to it.

Top module: `spi_run_ctrl_master`

## Requirements
- R1: After reset, `running`=0, `cs_n`=1, `sck`=0, `eoq_flag`=0, `tx_full`=0, `rx_empty`=1, and all three error flags are 0.
- R2: From the stopped state, `running` becomes 1 one clock after `cfg_halt`=0, `eoq_flag`=0 and the freeze condition is false. It stays 0 while any of them is active.
- R3: The stop condition is `cfg_halt`=1, or `eoq_flag`=1, or (`cfg_debug`=1 and `cfg_freeze`=1). `cfg_freeze` has no effect while `cfg_debug`=0.
- R4: When a stop condition appears with no frame in progress, `running` drops one clock later. During a frame it drops one clock after the frame ends, and the frame completes with all of its bits.
- R5: A frame starts only while `running`=1, no stop condition is present and the transmit queue is not empty. While the machine is stopped, pushes are still accepted and no frame starts.
- R6: `cfg_len` is clamped to the range 4..16. A frame carries the low `len` bits of the word, most significant bit first, in SPI mode 0: `sck` idles low, `mosi` changes on the falling edge, `miso` is sampled on the rising edge, and one `sck` period lasts CLK_DIV clocks.
- R7: `cs_n` is low for exactly len×CLK_DIV clocks per frame and goes high for at least one clock between frames.
- R8: Each received frame is pushed to the receive queue as one word, right-aligned, with the bits above `len` set to zero.
- R9: A transmit word pushed with `tx_eoq`=1 sets `eoq_flag` when its frame ends. A one-clock pulse on `eoq_clr` clears the flag.
- R10: Each queue holds 4 words. A push to a full queue is dropped and sets its sticky overflow flag (`tx_ovf` or `rx_ovf`).
- R11: A pop of the empty receive queue leaves `rx_data` unchanged and sets the sticky `rx_udf`.
- R12: `rx_data` shows the popped word one clock after a `rx_pop` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_halt | input | 1 | Halt request |
| cfg_debug | input | 1 | Debug mode active |
| cfg_freeze | input | 1 | Freeze request, honoured only in debug mode |
| cfg_len | input | LEN_W | Frame length request, clamped to 4..DATA_W |
| eoq_clr | input | 1 | Write-one-to-clear pulse for eoq_flag |
| eoq_flag | output | 1 | Sticky end-of-queue flag |
| running | output | 1 | 1 while in the running state |
| tx_push | input | 1 | Push into the transmit queue |
| tx_data | input | DATA_W | Transmit word |
| tx_eoq | input | 1 | End-of-queue marker stored with the word |
| tx_full | output | 1 | Transmit queue full |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_pop | input | 1 | Pop from the receive queue |
| rx_data | output | DATA_W | Last popped received word |
| rx_empty | output | 1 | Receive queue empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| rx_udf | output | 1 | Sticky receive underflow |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
Two events can meet in one cycle: a stop request and the end of a frame. A second frame could also become ready to start just as the end-of-queue flag is being raised. The bench raises halt while a frame is mid-shift, with a second word already queued. It also queues a marked word followed by an unmarked one. In both cases it checks three things: the first frame keeps its full chip-select length, `running` falls exactly one clock after chip select rises, and chip select stays high afterwards until the inhibit is removed.

// File: rtl/spi_rc_pkg.sv
package spi_rc_pkg;

  typedef enum logic {
    ST_STOPPED = 1'b0,
    ST_RUNNING = 1'b1
  } run_state_e;

  localparam int unsigned MIN_LEN = 4;

  // Clamp a requested frame length into MIN_LEN..max_len.
  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned max_len);
    if (req < MIN_LEN) return MIN_LEN;
    if (req > max_len) return max_len;
    return req;
  endfunction

  // Half of the serial clock period in system clocks.
  function automatic int unsigned half_period(input int unsigned div);
    return (div < 2) ? 1 : div / 2;
  endfunction

endpackage

// File: rtl/spi_rc_fifo.sv
module spi_rc_fifo #(
  parameter int W     = 17,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty,
  output logic         ovf,
  output logic         udf
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] DEPTH_C  = CNTW'(DEPTH);

  logic [W-1:0]    mem [DEPTH];
  logic [AW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] count_q;
  logic            push_ok, pop_ok;

  assign full    = (count_q == DEPTH_C);
  assign empty   = (count_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign head    = mem[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q    <= '0;
      rd_q    <= '0;
      count_q <= '0;
      rdata   <= '0;
      ovf     <= 1'b0;
      udf     <= 1'b0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok) begin
        rd_q  <= nxt(rd_q);
        rdata <= mem[rd_q];
      end
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
      if (push && full) ovf <= 1'b1;
      if (pop && empty) udf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= wdata;
  end

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count_q <= DEPTH_C); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (full && push && !pop) |=> full); // R10
  AST_OVF_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf); // R10
  AST_UDF_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) (empty && pop) |=> $stable(rdata)); // R11
  AST_UDF_STICKY:  assert property (@(posedge clk) disable iff (!rst_n) udf |=> udf); // R11

endmodule

// File: rtl/spi_rc_runctl.sv
module spi_rc_runctl
  import spi_rc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt,
  input  logic debug,
  input  logic freeze,
  input  logic eoq_set,
  input  logic eoq_clr,
  input  logic frame_busy,
  output logic stop_req,
  output logic eoq_flag,
  output logic running
);
  run_state_e state_q;

  assign stop_req = eoq_flag | halt | (debug & freeze);
  assign running  = (state_q == ST_RUNNING);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoq_flag <= 1'b0;
    end else if (eoq_set) begin
      eoq_flag <= 1'b1;
    end else if (eoq_clr) begin
      eoq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STOPPED;
    end else begin
      case (state_q)
        ST_STOPPED: if (!stop_req) state_q <= ST_RUNNING;
        ST_RUNNING: if (stop_req && !frame_busy) state_q <= ST_STOPPED;
        default:    state_q <= ST_STOPPED;
      endcase
    end
  end

  AST_START_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (!running && !stop_req) |=> running); // R2
  AST_STAY_STOPPED:     assert property (@(posedge clk) disable iff (!rst_n) (!running && stop_req) |=> !running); // R3
  AST_HOLD_IN_FRAME:    assert property (@(posedge clk) disable iff (!rst_n) (running && frame_busy) |=> running); // R4
  AST_STOP_WHEN_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) (running && stop_req && !frame_busy) |=> !running); // R4
  AST_EOQ_STICKY:       assert property (@(posedge clk) disable iff (!rst_n) (eoq_flag && !eoq_clr) |=> eoq_flag); // R9

endmodule

// File: rtl/spi_rc_shifter.sv
module spi_rc_shifter
  import spi_rc_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int CLK_DIV = 4,
  parameter int LEN_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_ok,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              tx_mark,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              frame_done,
  output logic              frame_mark,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              cs_n
);
  localparam int HALF = int'(half_period(CLK_DIV));
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BCW  = $clog2(DATA_W + 1);
  localparam logic [CW-1:0]  DIV_LAST = CW'(HALF - 1);
  localparam logic [BCW-1:0] DW_L     = BCW'(DATA_W);

  logic              busy_q, sck_q, mark_q;
  logic [CW-1:0]     div_q;
  logic [BCW-1:0]    bit_q, len_q, len_c;
  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic              start_fire, edge_tick, rise_ev, fall_ev, last_ev;

  assign len_c      = BCW'(clamp_len(int'(cfg_len), DATA_W));
  assign start_fire = run_ok & tx_avail & ~busy_q;
  assign edge_tick  = busy_q & (div_q == DIV_LAST);
  assign rise_ev    = edge_tick & ~sck_q;
  assign fall_ev    = edge_tick & sck_q;
  assign last_ev    = fall_ev & (bit_q == len_q - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mark_q <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      len_q  <= BCW'(MIN_LEN);
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (start_fire) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      div_q  <= '0;
      bit_q  <= '0;
      len_q  <= len_c;
      mark_q <= tx_mark;
      tx_sh  <= tx_word << (DW_L - len_c);
      rx_sh  <= '0;
    end else if (busy_q) begin
      if (edge_tick) begin
        div_q <= '0;
        sck_q <= ~sck_q;
        if (rise_ev) rx_sh <= {rx_sh[DATA_W-2:0], miso};
        if (fall_ev) begin
          if (last_ev) begin
            busy_q <= 1'b0;
          end else begin
            bit_q <= bit_q + 1'b1;
            tx_sh <= tx_sh << 1;
          end
        end
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  assign tx_pop     = start_fire;
  assign rx_push    = last_ev;
  assign rx_word    = rx_sh;
  assign frame_done = last_ev;
  assign frame_mark = mark_q;
  assign busy       = busy_q;
  assign sck        = sck_q;
  assign mosi       = busy_q & tx_sh[DATA_W-1];
  assign cs_n       = ~busy_q;

  AST_CS_LOW_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n) start_fire |=> !cs_n); // R7
  AST_SCK_IDLE_LOW:       assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck); // R6
  AST_CS_GAP:             assert property (@(posedge clk) disable iff (!rst_n) frame_done |=> cs_n); // R7
  AST_MOSI_ON_FALL:       assert property (@(posedge clk) disable iff (!rst_n) (busy_q && !fall_ev && !start_fire) |=> $stable(mosi)); // R6

endmodule

// File: rtl/spi_run_ctrl_master.sv
module spi_run_ctrl_master
  import spi_rc_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 4,
  parameter int CLK_DIV    = 4,
  parameter int LEN_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_halt,
  input  logic              cfg_debug,
  input  logic              cfg_freeze,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              eoq_clr,
  output logic              eoq_flag,
  output logic              running,
  input  logic              tx_push,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_eoq,
  output logic              tx_full,
  output logic              tx_ovf,
  input  logic              rx_pop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_empty,
  output logic              rx_ovf,
  output logic              rx_udf,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int TXW = DATA_W + 1;

  logic [TXW-1:0]    tx_head, tx_rdata_unused;
  logic [DATA_W-1:0] rx_head_unused, rx_word;
  logic              tx_empty, tx_udf_unused, rx_full_unused;
  logic              tx_pop, rx_push, frame_done, frame_mark, busy, stop_req;

  spi_rc_fifo #(.W(TXW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .wdata({tx_eoq, tx_data}), .pop(tx_pop),
    .head(tx_head), .rdata(tx_rdata_unused),
    .full(tx_full), .empty(tx_empty), .ovf(tx_ovf), .udf(tx_udf_unused)
  );

  spi_rc_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_word), .pop(rx_pop),
    .head(rx_head_unused), .rdata(rx_data),
    .full(rx_full_unused), .empty(rx_empty), .ovf(rx_ovf), .udf(rx_udf)
  );

  spi_rc_runctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .halt(cfg_halt), .debug(cfg_debug), .freeze(cfg_freeze),
    .eoq_set(frame_done & frame_mark), .eoq_clr(eoq_clr),
    .frame_busy(busy), .stop_req(stop_req),
    .eoq_flag(eoq_flag), .running(running)
  );

  spi_rc_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .LEN_W(LEN_W)) u_shf (
    .clk(clk), .rst_n(rst_n),
    .run_ok(running & ~stop_req), .tx_avail(~tx_empty),
    .tx_word(tx_head[DATA_W-1:0]), .tx_mark(tx_head[DATA_W]),
    .cfg_len(cfg_len), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .frame_done(frame_done), .frame_mark(frame_mark), .busy(busy),
    .sck(sck), .mosi(mosi), .cs_n(cs_n)
  );

  AST_POP_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> (running && !cfg_halt)); // R5
  AST_NO_POP_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> !tx_empty); // R5
  AST_EOQ_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(eoq_flag) |-> cs_n); // R9

endmodule

// File: tb/spi_run_ctrl_master_test.sv
module spi_run_ctrl_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_halt = 1'b1, cfg_debug = 1'b0, cfg_freeze = 1'b0, eoq_clr = 1'b0;
  logic [4:0] cfg_len = 5'd8;
  logic tx_push = 1'b0, tx_eoq = 1'b0, rx_pop = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic eoq_flag, running, tx_full, tx_ovf, rx_empty, rx_ovf, rx_udf, sck, mosi, miso, cs_n;
  logic [DW-1:0] rx_data;
  logic [1:0] miso_sel = 2'd0;

  assign miso = (miso_sel == 2'd0) ? mosi : (miso_sel == 2'd1);

  spi_run_ctrl_master uut (
    .clk(clk), .rst_n(rst_n), .cfg_halt(cfg_halt), .cfg_debug(cfg_debug),
    .cfg_freeze(cfg_freeze), .cfg_len(cfg_len), .eoq_clr(eoq_clr),
    .eoq_flag(eoq_flag), .running(running), .tx_push(tx_push),
    .tx_data(tx_data), .tx_eoq(tx_eoq), .tx_full(tx_full), .tx_ovf(tx_ovf),
    .rx_pop(rx_pop), .rx_data(rx_data), .rx_empty(rx_empty), .rx_ovf(rx_ovf),
    .rx_udf(rx_udf), .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mon_bits = '0;
  int mon_rises = 0;

  // Bits seen on mosi at each rising sck edge; cleared when a frame begins.
  always @(posedge sck or negedge cs_n) begin
    if (sck) begin
      mon_bits  <= {mon_bits[DW-2:0], mosi};
      mon_rises <= mon_rises + 1;
    end else begin
      mon_bits  <= '0;
      mon_rises <= 0;
    end
  end

  typedef struct packed {
    logic [4:0]    len;
    logic [DW-1:0] data;
    logic [DW-1:0] exp_word;
    logic [4:0]    exp_bits;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{5'd8,  16'h00A5, 16'h00A5, 5'd8},
    '{5'd4,  16'h123C, 16'h000C, 5'd4},
    '{5'd16, 16'hBEEF, 16'hBEEF, 5'd16},
    '{5'd2,  16'h0007, 16'h0007, 5'd4},
    '{5'd20, 16'h8001, 16'h8001, 5'd16},
    '{5'd12, 16'hFABC, 16'h0ABC, 5'd12}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic push_tx(input logic [DW-1:0] d, input logic m);
    tx_data = d; tx_eoq = m; tx_push = 1'b1;
    tick();
    tx_push = 1'b0; tx_eoq = 1'b0;
  endtask

  task automatic pop_rx(output logic [DW-1:0] v);
    rx_pop = 1'b1;
    tick();
    rx_pop = 1'b0;
    v = rx_data;
  endtask

  task automatic run_frame(output int low);
    while (cs_n) tick();
    low = 0;
    while (!cs_n) begin low++; tick(); end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int low;
    logic [DW-1:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    check("R1 running", running, 0);
    check("R1 cs_n", cs_n, 1);
    check("R1 sck", sck, 0);
    check("R1 eoq_flag", eoq_flag, 0);
    check("R1 tx_full", tx_full, 0);
    check("R1 rx_empty", rx_empty, 1);
    check("R1 flags", {tx_ovf, rx_ovf, rx_udf}, 0);

    // Vector table: loopback frames of several lengths (R6 R7 R8)
    for (int i = 0; i < 6; i++) begin
      cfg_halt = 1'b1; tick(); tick();
      cfg_len = VECS[i].len;
      push_tx(VECS[i].data, 1'b0);
      cfg_halt = 1'b0;
      run_frame(low);
      check("R7 cs_n low cycles", low, VECS[i].exp_bits * DIV);
      check("R6 mosi bits msb first", mon_bits, VECS[i].exp_word);
      check("R6 sck rises", mon_rises, VECS[i].exp_bits);
      check("R7 cs_n high after frame", cs_n, 1);
      pop_rx(v);
      check("R8 rx word", v, VECS[i].exp_word);
    end

    // R2 R3 start and stop conditions with an idle link
    cfg_halt = 1'b1; tick(); tick();
    repeat (4) tick();
    check("R2 held stopped by halt", running, 0);
    cfg_halt = 1'b0; tick();
    check("R2 starts one clock after clear", running, 1);
    cfg_debug = 1'b1; tick(); tick();
    check("R3 debug alone does not stop", running, 1);
    cfg_freeze = 1'b1; tick();
    check("R3 R4 freeze in debug stops next clock", running, 0);
    cfg_debug = 1'b0; tick();
    check("R3 freeze ignored outside debug", running, 1);
    cfg_freeze = 1'b0;
    cfg_halt = 1'b1; tick();
    check("R3 halt stops", running, 0);

    // R4 graceful stop with a second word waiting
    cfg_len = 5'd16;
    push_tx(16'hC3C3, 1'b0);
    push_tx(16'h1111, 1'b0);
    cfg_halt = 1'b0;
    while (cs_n) tick();
    low = 0;
    repeat (10) begin low++; tick(); end
    cfg_halt = 1'b1;
    check("R4 still running mid-frame", running, 1);
    while (!cs_n) begin low++; tick(); end
    check("R4 frame length kept", low, 16 * DIV);
    check("R4 sck rises kept", mon_rises, 16);
    tick();
    check("R4 stops after frame end", running, 0);
    repeat (20) tick();
    check("R5 no frame while stopped", cs_n, 1);
    pop_rx(v);
    check("R8 first word", v, 16'hC3C3);
    cfg_halt = 1'b0;
    run_frame(low);
    pop_rx(v);
    check("R5 queued word sent after restart", v, 16'h1111);

    // R10 R11 queue limits
    cfg_halt = 1'b1; tick(); tick();
    cfg_len = 5'd8;
    push_tx(16'h0011, 1'b0);
    push_tx(16'h0022, 1'b0);
    push_tx(16'h0033, 1'b0);
    push_tx(16'h0044, 1'b0);
    check("R10 tx_full", tx_full, 1);
    check("R10 tx_ovf clear before overflow", tx_ovf, 0);
    push_tx(16'h0055, 1'b0);
    check("R10 tx_ovf set", tx_ovf, 1);
    repeat (10) tick();
    check("R5 stopped keeps cs_n high", cs_n, 1);
    cfg_halt = 1'b0;
    repeat (4) run_frame(low);
    check("R10 rx_ovf clear with 4 words", rx_ovf, 0);
    push_tx(16'h0066, 1'b0);
    run_frame(low);
    tick();
    check("R10 rx_ovf set", rx_ovf, 1);
    pop_rx(v); check("R10 R12 pop 1", v, 16'h0011);
    pop_rx(v); check("R10 pop 2", v, 16'h0022);
    pop_rx(v); check("R10 pop 3", v, 16'h0033);
    pop_rx(v); check("R10 pop 4 extra words dropped", v, 16'h0044);
    check("R11 rx_udf clear before", rx_udf, 0);
    pop_rx(v);
    check("R11 empty pop keeps data", v, 16'h0044);
    check("R11 rx_udf set", rx_udf, 1);
    check("R11 rx_empty", rx_empty, 1);

    // R9 end-of-queue marker
    cfg_halt = 1'b1; tick(); tick();
    push_tx(16'h00A1, 1'b1);
    push_tx(16'h00B2, 1'b0);
    cfg_halt = 1'b0;
    run_frame(low);
    check("R9 eoq_flag set at frame end", eoq_flag, 1);
    tick();
    check("R9 R3 eoq stops", running, 0);
    repeat (16) tick();
    check("R9 no frame while flag set", cs_n, 1);
    eoq_clr = 1'b1; tick(); eoq_clr = 1'b0;
    check("R9 flag cleared", eoq_flag, 0);
    run_frame(low);
    pop_rx(v); check("R9 marked word", v, 16'h00A1);
    pop_rx(v); check("R9 next word after clear", v, 16'h00B2);

    // R8 zero fill with a constant return line, R6 with a silent line
    miso_sel = 2'd1;
    cfg_len = 5'd6;
    push_tx(16'h0000, 1'b0);
    run_frame(low);
    pop_rx(v);
    check("R8 ones right-aligned", v, 16'h003F);
    miso_sel = 2'd2;
    cfg_len = 5'd5;
    push_tx(16'hFFFF, 1'b0);
    run_frame(low);
    check("R6 low bits only", mon_bits, 16'h001F);
    pop_rx(v);
    check("R8 zeros received", v, 16'h0000);

    summary();
    $finish;
  end
endmodule